// File: doc/BRIEF.md
# Zig-Zag Constellation Enumeration Generator

This block sets the order in which the top-level children of a square-QAM search tree are visited. For each vector symbol it takes the interference-cancelled complex point and the diagonal channel gain of the top level. It then emits every grid point once, one per clock. Points near the received value come out first, so a downstream radius test can prune the later, unlikely ones.

The order needs no distance metric. Each axis gets its own zig-zag order. That order starts at the nearest level, then alternates outward, beginning on the side where the unquantized coordinate lies. When one side runs out at the edge of the grid, the remaining levels on the other side follow in increasing distance. The grid is walked column by column. The real level stays fixed while the imaginary level runs through its whole zig-zag order, and then the next real level in the real-axis order is taken. The nearest level and the first side come from comparisons against gain-scaled thresholds, with no division. A new-symbol flag marks the first point of each symbol so that downstream logic can open its radius fully. A last flag marks the final point.

Top module: `zz_enum`

## Requirements
- R1: After reset, `pt_valid`, `pt_first` and `pt_last` are 0 and `ready` is 1.
- R2: Per axis, the first level is the odd level L in -(LV-1)..(LV-1) nearest to c/r. A coordinate exactly midway between two levels takes the higher one. The gain r must be at least 1.
- R3: Per axis, the second level lies above the first when c >= L*r, otherwise below it. A coordinate exactly at L*r therefore goes upward first.
- R4: Per axis, the levels after the first alternate sides at growing distance 1, 2, 3, ... in level-index steps. Once one side reaches the grid edge, the other side continues in order of increasing distance.
- R5: Within a symbol, the real level stays constant for LV consecutive points while the imaginary level runs through its full axis order. The real level then moves to the next entry of the real-axis order.
- R6: Each accepted start yields exactly LV*LV consecutive valid points, one per cycle, and no grid point appears twice.
- R7: `pt_first` is 1 on the first point of a symbol and 0 on every other cycle.
- R8: `pt_last` is 1 on the LV*LV-th point only. A start presented in that same cycle is accepted and its first point appears in the next cycle. Without such a start, `pt_valid` drops in the next cycle.
- R9: A start presented while a symbol is in progress and not on its last point is ignored. The sequence in flight continues unchanged.
- R10: The first point of a symbol appears in the cycle after the clock edge that accepts `start`. `ready` is 1 exactly when the block is idle or showing its last point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new symbol with the coordinates present |
| c_re | input | CW | Cancelled point, real part, two's complement |
| c_im | input | CW | Cancelled point, imaginary part, two's complement |
| r_gain | input | GW | Top-level diagonal gain, unsigned, at least 1 |
| ready | output | 1 | A start in this cycle will be accepted |
| pt_valid | output | 1 | A grid point is presented |
| pt_re | output | $clog2(LV)+1 | Real level, odd signed value |
| pt_im | output | $clog2(LV)+1 | Imaginary level, odd signed value |
| pt_first | output | 1 | First point of a symbol |
| pt_last | output | 1 | Last point of a symbol |

## Verification
Two situations are hard to reach: a coordinate that sits exactly on a decision threshold or exactly on a level centre, and a start that arrives precisely in the cycle of the last point. The stimulus uses a gain of 16 with coordinates of 32 and 16 to hit both tie rules exactly. Coordinates far beyond the outer levels make one side of an axis run out at once. The bench tracks the remaining points of the symbol in flight, so it can raise `start` on the last-point cycle, and also a few cycles earlier to show that the early request is dropped.

// File: rtl/zz_enum_pkg.sv
package zz_enum_pkg;
   function automatic bit zz_is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int zz_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/zz_slice.sv
module zz_slice
   import zz_enum_pkg::*;
#(
   parameter int LV = 8,
   parameter int CW = 12,
   parameter int GW = 8,
   localparam int IW = $clog2(LV)
) (
   input  logic signed [CW-1:0] coord,
   input  logic        [GW-1:0] gain,
   output logic        [IW-1:0] near_idx,
   output logic                 go_up
);
   localparam int PW = zz_max(CW, GW + IW + 2) + 1;

   logic signed [PW-1:0] c_ext;
   logic signed [PW-1:0] g_ext;
   logic [LV-2:0]        above;
   logic signed [PW-1:0] lvl_s;
   logic signed [PW-1:0] centre;

   assign c_ext = PW'(coord);
   assign g_ext = signed'({{(PW-GW){1'b0}}, gain});

   for (genvar k = 1; k < LV; k++) begin : g_thr
      localparam int K = 2 * k - LV;
      logic signed [PW-1:0] thr;
      assign thr          = PW'(K) * g_ext;
      assign above[k-1]   = (c_ext >= thr);
   end

   always_comb begin
      near_idx = '0;
      for (int k = 0; k < LV - 1; k++) begin
         near_idx = near_idx + IW'(above[k]);
      end
   end

   assign lvl_s  = PW'(2 * int'(near_idx) - (LV - 1));
   assign centre = lvl_s * g_ext;
   assign go_up  = (c_ext >= centre);
endmodule

// File: rtl/zz_axis.sv
module zz_axis #(
   parameter int LV = 8,
   localparam int IW = $clog2(LV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          rewind,
   input  logic          step,
   input  logic [IW-1:0] base_idx,
   input  logic          base_up,
   output logic [IW-1:0] idx_o
);
   logic [IW-1:0] base_q;
   logic          up_q;
   logic [IW-1:0] cur;
   logic [IW:0]   hi;
   logic [IW:0]   lo_p1;
   logic [IW:0]   lo_m1;
   logic          prefer_up;
   logic          take_up;
   logic [IW-1:0] seed_idx;
   logic          seed_up;

   assign seed_idx = load ? base_idx : base_q;
   assign seed_up  = load ? base_up  : up_q;
   assign take_up  = (prefer_up && (hi < (IW+1)'(LV))) || (lo_p1 == '0);
   assign lo_m1    = lo_p1 - 1'b1;
   assign idx_o    = cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         up_q      <= 1'b0;
         cur       <= '0;
         hi        <= '0;
         lo_p1     <= '0;
         prefer_up <= 1'b0;
      end else if (load || rewind) begin
         cur       <= seed_idx;
         hi        <= {1'b0, seed_idx} + 1'b1;
         lo_p1     <= {1'b0, seed_idx};
         prefer_up <= seed_up;
         if (load) begin
            base_q <= base_idx;
            up_q   <= base_up;
         end
      end else if (step) begin
         if (take_up) begin
            cur       <= hi[IW-1:0];
            hi        <= hi + 1'b1;
            prefer_up <= 1'b0;
         end else begin
            cur       <= lo_m1[IW-1:0];
            lo_p1     <= lo_m1;
            prefer_up <= 1'b1;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !rewind) |-> ((hi < (IW+1)'(LV)) || (lo_p1 != '0))); // R6

   AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !rewind) |=> (cur != $past(cur))); // R4
endmodule

// File: rtl/zz_enum.sv
module zz_enum
   import zz_enum_pkg::*;
#(
   parameter int LV = 8,
   parameter int CW = 12,
   parameter int GW = 8,
   localparam int IW = $clog2(LV)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic signed [CW-1:0] c_re,
   input  logic signed [CW-1:0] c_im,
   input  logic        [GW-1:0] r_gain,
   output logic                 ready,
   output logic                 pt_valid,
   output logic signed [IW:0]   pt_re,
   output logic signed [IW:0]   pt_im,
   output logic                 pt_first,
   output logic                 pt_last
);
   initial begin
      assert (zz_is_pow2(LV)) else $error("LV must be a power of two >= 2");
      assert (CW >= 2)        else $error("CW too small");
      assert (GW >= 1)        else $error("GW too small");
   end

   localparam logic [IW-1:0] CNT_END = IW'(LV - 1);

   logic [IW-1:0] re_cnt;
   logic [IW-1:0] im_cnt;
   logic          valid_q;
   logic          accept;
   logic          advance;
   logic          col_end;
   logic [IW-1:0] near_re, near_im;
   logic          up_re, up_im;
   logic [IW-1:0] idx_re, idx_im;

   zz_slice #(.LV(LV), .CW(CW), .GW(GW)) u_slice_re (
      .coord(c_re), .gain(r_gain), .near_idx(near_re), .go_up(up_re));
   zz_slice #(.LV(LV), .CW(CW), .GW(GW)) u_slice_im (
      .coord(c_im), .gain(r_gain), .near_idx(near_im), .go_up(up_im));

   assign pt_last = valid_q && (re_cnt == CNT_END) && (im_cnt == CNT_END);
   assign ready   = !valid_q || pt_last;
   assign accept  = start && ready;
   assign advance = valid_q && !pt_last && !accept;
   assign col_end = (im_cnt == CNT_END);

   zz_axis #(.LV(LV)) u_axis_re (
      .clk(clk), .rst_n(rst_n), .load(accept), .rewind(1'b0),
      .step(advance && col_end), .base_idx(near_re), .base_up(up_re),
      .idx_o(idx_re));
   zz_axis #(.LV(LV)) u_axis_im (
      .clk(clk), .rst_n(rst_n), .load(accept), .rewind(advance && col_end),
      .step(advance && !col_end), .base_idx(near_im), .base_up(up_im),
      .idx_o(idx_im));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         re_cnt  <= '0;
         im_cnt  <= '0;
      end else if (accept) begin
         valid_q <= 1'b1;
         re_cnt  <= '0;
         im_cnt  <= '0;
      end else if (advance) begin
         im_cnt <= im_cnt + 1'b1;
         if (col_end) re_cnt <= re_cnt + 1'b1;
      end else if (pt_last) begin
         valid_q <= 1'b0;
      end
   end

   logic signed [IW+1:0] re_full, im_full;
   assign re_full  = signed'({1'b0, idx_re, 1'b1}) - (IW+2)'(LV);
   assign im_full  = signed'({1'b0, idx_im, 1'b1}) - (IW+2)'(LV);
   assign pt_re    = re_full[IW:0];
   assign pt_im    = im_full[IW:0];
   assign pt_valid = valid_q;
   assign pt_first = valid_q && (re_cnt == '0) && (im_cnt == '0);

   AST_FIRST_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      pt_first |-> !pt_last); // R7

   AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_valid && !pt_last && !start && im_cnt != CNT_END) |=> $stable(pt_re)); // R5

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && pt_valid && !pt_last) |=> (pt_valid && !pt_first)); // R9

   AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_last && !start) |=> !pt_valid); // R8

   AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_last && start) |=> pt_first); // R8

   AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !pt_valid) |=> pt_first); // R10
endmodule

// File: tb/tb_zz_enum.sv
module tb_zz_enum;
   localparam int LV = 8;
   localparam int CW = 12;
   localparam int GW = 8;
   localparam int NP = LV * LV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic signed [CW-1:0] c_re = '0, c_im = '0;
   logic [GW-1:0] r_gain = 8'd1;
   logic ready, pt_valid, pt_first, pt_last;
   logic signed [3:0] pt_re, pt_im;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int qre[$], qim[$], qpos[$];
   bit seen[NP];
   int seen_cnt = 0;

   always #10 clk = ~clk;

   zz_enum #(.LV(LV), .CW(CW), .GW(GW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .c_re(c_re), .c_im(c_im),
      .r_gain(r_gain), .ready(ready), .pt_valid(pt_valid), .pt_re(pt_re),
      .pt_im(pt_im), .pt_first(pt_first), .pt_last(pt_last));

   task automatic check(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycles);
      end
   endtask

   // axis order by distance from nearest level, side preference from tie rules
   task automatic axis_order(input int c, input int r, output int ord[LV]);
      int best = 0;
      int bd = 1 << 30;
      int n = 1;
      bit up;
      for (int i = 0; i < LV; i++) begin
         int d = c - (2 * i - (LV - 1)) * r;
         if (d < 0) d = -d;
         if (d <= bd) begin bd = d; best = i; end
      end
      up = (c >= (2 * best - (LV - 1)) * r);
      ord[0] = best;
      for (int d = 1; d < LV; d++) begin
         int a = up ? best + d : best - d;
         int b = up ? best - d : best + d;
         if (a >= 0 && a < LV) begin ord[n] = a; n++; end
         if (b >= 0 && b < LV) begin ord[n] = b; n++; end
      end
   endtask

   task automatic cyc(input bit st, input int cr, input int ci, input int r, input string tag);
      bit acc;
      start = st; c_re = CW'(cr); c_im = CW'(ci); r_gain = GW'(r);
      check("R10", int'(ready), int'(qre.size() <= 1), "ready");
      acc = st && (qre.size() <= 1);
      if (qre.size() > 0) begin
         void'(qre.pop_front()); void'(qim.pop_front()); void'(qpos.pop_front());
      end
      if (acc) begin
         int ore[LV], oim[LV];
         axis_order(cr, r, ore);
         axis_order(ci, r, oim);
         for (int a = 0; a < LV; a++)
            for (int b = 0; b < LV; b++) begin
               qre.push_back(2 * ore[a] - (LV - 1));
               qim.push_back(2 * oim[b] - (LV - 1));
               qpos.push_back(a * LV + b);
            end
      end
      @(posedge clk);
      @(negedge clk);
      cycles++;
      start = 1'b0;
      if (qre.size() == 0) begin
         check("R8", int'(pt_valid), 0, "valid idle");
         check("R7", int'(pt_first), 0, "first idle");
      end else begin
         int p = qpos[0];
         string t = (p == 0) ? "R2" : (p == 1) ? "R3" : (p % LV == 0) ? "R5" : tag;
         check("R6", int'(pt_valid), 1, "valid");
         check(t, int'(pt_re), qre[0], "real level");
         check(t, int'(pt_im), qim[0], "imag level");
         check("R7", int'(pt_first), int'(p == 0), "first flag");
         check("R8", int'(pt_last), int'(p == NP - 1), "last flag");
         if (pt_first) begin
            foreach (seen[k]) seen[k] = 1'b0;
            seen_cnt = 0;
         end
         if (!seen[(int'(pt_re) + 7) / 2 * LV + (int'(pt_im) + 7) / 2]) seen_cnt++;
         seen[(int'(pt_re) + 7) / 2 * LV + (int'(pt_im) + 7) / 2] = 1'b1;
         if (pt_last) check("R6", seen_cnt, NP, "distinct points");
      end
   endtask

   initial begin : watchdog
      #(20 * 5000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(pt_valid), 0, "valid in reset");
      check("R1", int'(ready), 1, "ready in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(pt_first), 0, "first after reset");
      check("R1", int'(pt_last), 0, "last after reset");
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, "R1");

      // interior point: real below level 3, imag just above level -1
      cyc(1, 47, -15, 20, "R4");
      for (int i = 0; i < NP + 2; i++) cyc(0, 0, 0, 1, "R4");

      // far outside the grid on both axes: one side exhausted at once
      cyc(1, 200, -300, 10, "R4");
      for (int i = 0; i < NP + 1; i++) cyc(0, 0, 0, 1, "R4");

      // exact threshold on real, exact centre on imag; early starts ignored
      cyc(1, 32, 16, 16, "R4");
      for (int i = 0; i < NP - 1; i++)
         cyc(i >= 10 && i <= 12, -90, 70, 30, (i >= 10 && i <= 13) ? "R9" : "R4");
      // start coincides with the last point: accepted back to back
      cyc(1, -5, 100, 3, "R8");
      for (int i = 0; i < NP + 2; i++) cyc(0, 0, 0, 1, "R4");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule